// File: doc/BRIEF.md
# Cascadable FIR and Pixel Convolver

This block is a pipelined multiply-accumulate engine. It takes up to three 12-bit signed sample streams, nine signed 10-bit weights and a 16-bit signed chain input. On every clock it produces one 16-bit chain output. A 2-bit mode input picks how the nine weights meet the delayed samples. The engine can act as a 9-tap FIR filter that is fed the same sample on two ports. It can act as a 3x3 pixel kernel over three line-delayed rows. It can also act as a 4x2 pixel kernel over two rows. The products are summed at full precision and rounded by half an LSB. The chain input is then added, so several instances can be wired output-to-input to build larger kernels.

One shared bank of sample delay registers feeds a mode-controlled tap router. Each mode has its own fixed input-to-output latency. The chain input always takes a shorter path than the samples, so a partial sum from an upstream instance lines up with the local products. After reset, and after any change of mode, the output is flagged not valid and held at zero until the new mode's whole delay window has refilled with samples taken under that mode.

Top module: `conv_cascade_mac`

## Requirements
- R1: On any clock edge where rst is high, chain_valid and chain_out are 0 after that edge.
- R2: mode_sel encodes 00 = idle, 01 = FIR, 10 = 3x3 kernel, 11 = 4x2 kernel. While idle, chain_valid stays 0 and chain_out stays 0.
- R3: Let X[e] be port X as sampled at edge e, and let wi be the weight in coef_bus[10i+9:10i]. In FIR mode the product sum P for the output after edge t is w2·A[t-4] + w1·A[t-5] + w0·A[t-6] + w5·B[t-7] + w4·B[t-8] + w3·B[t-9] + w8·B[t-10] + w7·B[t-11] + w6·B[t-12].
- R4: In 3x3 mode, P = w2·A[t-4] + w1·A[t-5] + w0·A[t-6] + w5·B[t-4] + w4·B[t-5] + w3·B[t-6] + w8·C[t-4] + w7·C[t-5] + w6·C[t-6].
- R5: In 4x2 mode, P = w2·A[t-4] + w1·A[t-5] + w0·A[t-6] + w8·A[t-7] + w5·B[t-4] + w4·B[t-5] + w3·B[t-6] + w6·B[t-7]. Weight w7 has no effect on the output in this mode.
- R6: The output after edge t is the rounded P plus chain_in sampled at edge t-3, taken modulo 2^16. Samples, weights, chain_in and chain_out are all two's complement. The weights used are those present at edge t-2.
- R7: Rounding is floor((P + 32) / 64), so an exact half rounds toward plus infinity. The sum is held at full width, so nine extreme products never wrap before rounding.
- R8: chain_valid after edge t is 1 exactly when mode_sel holds one non-idle value M on every edge t-L..t and rst is low on all of those edges. L is 12 for FIR, 6 for 3x3 and 7 for 4x2.
- R9: After an edge at which mode_sel differs from its value at the previous edge, chain_valid is 0. Whenever chain_valid is 0, chain_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode |
| smp_a | input | 12 | Sample stream A (row 1, or FIR sample) |
| smp_b | input | 12 | Sample stream B (row 2, or FIR sample copy) |
| smp_c | input | 12 | Sample stream C (row 3, 3x3 mode only) |
| coef_bus | input | 90 | Nine packed 10-bit signed weights, slot i at bits 10i+9:10i |
| chain_in | input | 16 | Partial sum from an upstream instance |
| chain_out | output | 16 | Rounded sum of products plus delayed chain input |
| chain_valid | output | 1 | chain_out holds a full-window result |

## Verification
A mode switch can land in the same cycle as a chain input that is still counted toward an output, and as samples that still sit inside the old window. The bench keeps chain_in and every sample stream random while it switches modes. Some switches are held for fewer cycles than the new latency, and some go through idle. A behavioural model built from the latency equations then judges each edge: the valid flag must fall at once and stay low for exactly the new mode's window, and the first valid output must mix no sample or chain value from the previous mode. The same model also checks the FIR impulse response, the unused 4x2 weight and the half-LSB rounding edges.

// File: rtl/conv_cascade_pkg.sv
package conv_cascade_pkg;

    localparam int SAMPLE_W  = 12;
    localparam int COEF_W    = 10;
    localparam int CHAIN_W   = 16;
    localparam int NUM_TAPS  = 9;
    localparam int PROD_W    = SAMPLE_W + COEF_W;
    localparam int ACC_W     = PROD_W + $clog2(NUM_TAPS) + 1;

    // delay-line shapes: first tap sits TAP_LEAD registers behind the port
    localparam int TAP_LEAD   = 1;
    localparam int A_DEPTH    = 4;
    localparam int B_DEPTH    = 9;
    localparam int C_DEPTH    = 3;
    localparam int CHAIN_LEAD = 2;

    localparam int LAT_FIR    = 12;
    localparam int LAT_GRID33 = 6;
    localparam int LAT_GRID42 = 7;
    localparam int MAX_LAT    = LAT_FIR;
    localparam int RUN_W      = $clog2(MAX_LAT + 2);

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'b00,
        MODE_FIR    = 2'b01,
        MODE_GRID33 = 2'b10,
        MODE_GRID42 = 2'b11
    } conv_mode_e;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef struct packed {
        sample_t smp;
        coef_t   wgt;
    } tap_pair_t;

    function automatic int mode_latency(conv_mode_e m);
        case (m)
            MODE_FIR:    return LAT_FIR;
            MODE_GRID33: return LAT_GRID33;
            MODE_GRID42: return LAT_GRID42;
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/conv_tap_delay.sv
module conv_tap_delay #(
    parameter int W     = 12,
    parameter int LEAD  = 1,
    parameter int COUNT = 4
) (
    input  logic                      clk,
    input  logic [W-1:0]              din,
    output logic [COUNT-1:0][W-1:0]   taps
);
    localparam int LEN = LEAD + COUNT;

    logic [LEN-1:0][W-1:0] line_q;

    always_ff @(posedge clk) begin
        line_q[0] <= din;
        for (int k = 1; k < LEN; k++) begin
            line_q[k] <= line_q[k-1];
        end
    end

    generate
        for (genvar j = 0; j < COUNT; j++) begin : g_tap
            assign taps[j] = line_q[LEAD + j];
        end
    endgenerate

endmodule

// File: rtl/conv_tap_router.sv
module conv_tap_router
    import conv_cascade_pkg::*;
(
    input  conv_mode_e                               mode,
    input  logic [A_DEPTH-1:0][SAMPLE_W-1:0]         a_taps,
    input  logic [B_DEPTH-1:0][SAMPLE_W-1:0]         b_taps,
    input  logic [C_DEPTH-1:0][SAMPLE_W-1:0]         c_taps,
    input  logic [NUM_TAPS*COEF_W-1:0]               coef_bus,
    output tap_pair_t [NUM_TAPS-1:0]                 pairs
);
    // tap index j of a delay line carries the sample taken 4+j edges
    // before the output edge
    sample_t smp_sel [NUM_TAPS];

    always_comb begin
        for (int i = 0; i < NUM_TAPS; i++) begin
            smp_sel[i] = '0;
        end
        case (mode)
            MODE_FIR: begin
                smp_sel[0] = sample_t'(a_taps[2]);
                smp_sel[1] = sample_t'(a_taps[1]);
                smp_sel[2] = sample_t'(a_taps[0]);
                smp_sel[3] = sample_t'(b_taps[5]);
                smp_sel[4] = sample_t'(b_taps[4]);
                smp_sel[5] = sample_t'(b_taps[3]);
                smp_sel[6] = sample_t'(b_taps[8]);
                smp_sel[7] = sample_t'(b_taps[7]);
                smp_sel[8] = sample_t'(b_taps[6]);
            end
            MODE_GRID33: begin
                smp_sel[0] = sample_t'(a_taps[2]);
                smp_sel[1] = sample_t'(a_taps[1]);
                smp_sel[2] = sample_t'(a_taps[0]);
                smp_sel[3] = sample_t'(b_taps[2]);
                smp_sel[4] = sample_t'(b_taps[1]);
                smp_sel[5] = sample_t'(b_taps[0]);
                smp_sel[6] = sample_t'(c_taps[2]);
                smp_sel[7] = sample_t'(c_taps[1]);
                smp_sel[8] = sample_t'(c_taps[0]);
            end
            MODE_GRID42: begin
                smp_sel[0] = sample_t'(a_taps[2]);
                smp_sel[1] = sample_t'(a_taps[1]);
                smp_sel[2] = sample_t'(a_taps[0]);
                smp_sel[3] = sample_t'(b_taps[2]);
                smp_sel[4] = sample_t'(b_taps[1]);
                smp_sel[5] = sample_t'(b_taps[0]);
                smp_sel[6] = sample_t'(b_taps[3]);
                smp_sel[8] = sample_t'(a_taps[3]);
            end
            default: ;
        endcase
    end

    generate
        for (genvar i = 0; i < NUM_TAPS; i++) begin : g_pair
            assign pairs[i].smp = smp_sel[i];
            assign pairs[i].wgt = coef_t'(coef_bus[i*COEF_W +: COEF_W]);
        end
    endgenerate

endmodule

// File: rtl/conv_mac_tree.sv
module conv_mac_tree
    import conv_cascade_pkg::*;
(
    input  logic                       clk,
    input  tap_pair_t [NUM_TAPS-1:0]   pairs,
    output acc_t                       sum_q
);
    prod_t prod_q [NUM_TAPS];
    acc_t  acc_d;

    generate
        for (genvar i = 0; i < NUM_TAPS; i++) begin : g_mul
            always_ff @(posedge clk) begin
                prod_q[i] <= prod_t'($signed(pairs[i].smp)) * prod_t'($signed(pairs[i].wgt));
            end
        end
    endgenerate

    always_comb begin
        acc_d = '0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            acc_d = acc_d + acc_t'(prod_q[i]);
        end
    end

    always_ff @(posedge clk) begin
        sum_q <= acc_d;
    end

endmodule

// File: rtl/conv_mode_tracker.sv
module conv_mode_tracker
    import conv_cascade_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  conv_mode_e  mode,
    output logic        valid_next
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    conv_mode_e       mode_q;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;

    // run_d counts the consecutive edges, this one included, that saw the
    // current non-idle mode with reset low
    always_comb begin
        if (rst || mode == MODE_IDLE) begin
            run_d = '0;
        end else if (mode != mode_q) begin
            run_d = RUN_W'(1);
        end else if (run_q == RUN_MAX) begin
            run_d = run_q;
        end else begin
            run_d = run_q + RUN_W'(1);
        end
        valid_next = (mode != MODE_IDLE) && (int'(run_d) >= mode_latency(mode) + 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_IDLE;
            run_q  <= '0;
        end else begin
            mode_q <= mode;
            run_q  <= run_d;
        end
    end

endmodule

// File: rtl/conv_cascade_mac.sv
module conv_cascade_mac
    import conv_cascade_pkg::*;
#(
    parameter int ROUND_SHIFT = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    mode_sel,
    input  logic [SAMPLE_W-1:0]           smp_a,
    input  logic [SAMPLE_W-1:0]           smp_b,
    input  logic [SAMPLE_W-1:0]           smp_c,
    input  logic [NUM_TAPS*COEF_W-1:0]    coef_bus,
    input  logic [CHAIN_W-1:0]            chain_in,
    output logic [CHAIN_W-1:0]            chain_out,
    output logic                          chain_valid
);
    localparam acc_t ROUND_HALF = acc_t'(1) <<< (ROUND_SHIFT - 1);

    conv_mode_e                        mode_e;
    logic [A_DEPTH-1:0][SAMPLE_W-1:0]  a_taps;
    logic [B_DEPTH-1:0][SAMPLE_W-1:0]  b_taps;
    logic [C_DEPTH-1:0][SAMPLE_W-1:0]  c_taps;
    logic [0:0][CHAIN_W-1:0]           chain_taps;
    tap_pair_t [NUM_TAPS-1:0]          pairs;
    acc_t                              sum_q;
    acc_t                              rounded;
    acc_t                              chain_ext;
    logic                              valid_next;

    assign mode_e = conv_mode_e'(mode_sel);

    conv_tap_delay #(.W(SAMPLE_W), .LEAD(TAP_LEAD), .COUNT(A_DEPTH)) u_dly_a (
        .clk (clk), .din (smp_a), .taps (a_taps)
    );
    conv_tap_delay #(.W(SAMPLE_W), .LEAD(TAP_LEAD), .COUNT(B_DEPTH)) u_dly_b (
        .clk (clk), .din (smp_b), .taps (b_taps)
    );
    conv_tap_delay #(.W(SAMPLE_W), .LEAD(TAP_LEAD), .COUNT(C_DEPTH)) u_dly_c (
        .clk (clk), .din (smp_c), .taps (c_taps)
    );
    // chain input: sampled value reaches the output register three edges on
    conv_tap_delay #(.W(CHAIN_W), .LEAD(CHAIN_LEAD), .COUNT(1)) u_dly_chain (
        .clk (clk), .din (chain_in), .taps (chain_taps)
    );

    conv_tap_router u_router (
        .mode     (mode_e),
        .a_taps   (a_taps),
        .b_taps   (b_taps),
        .c_taps   (c_taps),
        .coef_bus (coef_bus),
        .pairs    (pairs)
    );

    conv_mac_tree u_mac (
        .clk   (clk),
        .pairs (pairs),
        .sum_q (sum_q)
    );

    conv_mode_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .valid_next (valid_next)
    );

    assign rounded   = (sum_q + ROUND_HALF) >>> ROUND_SHIFT;
    assign chain_ext = acc_t'($signed(chain_taps[0]));

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_out   <= '0;
            chain_valid <= 1'b0;
        end else begin
            chain_valid <= valid_next;
            chain_out   <= valid_next ? CHAIN_W'(rounded + chain_ext) : '0;
        end
    end

    // idle mode never yields a valid result
    assert_idle_never_valid_R2: assert property (@(posedge clk) disable iff (rst)
        chain_valid |-> ($past(mode_sel) != MODE_IDLE))
        else $error("valid output under idle mode");

    // any mode switch drops validity on the following edge
    assert_flush_on_switch_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != $past(mode_sel)) |=> !chain_valid)
        else $error("valid survived a mode switch");

    // a valid result needs a steady mode over at least the last four edges
    assert_window_steady_R8: assert property (@(posedge clk) disable iff (rst)
        chain_valid |-> ($past(mode_sel, 1) == $past(mode_sel, 2) &&
                         $past(mode_sel, 2) == $past(mode_sel, 3) &&
                         $past(mode_sel, 3) == $past(mode_sel, 4)))
        else $error("valid asserted inside a mode transition window");

    // flushed output reads zero
    assert_quiet_when_invalid_R9: assert property (@(posedge clk) disable iff (rst)
        !chain_valid |-> (chain_out == '0))
        else $error("non-zero output while not valid");

endmodule

// File: tb/conv_cascade_mac_tb_top.sv
module conv_cascade_mac_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  mode_sel;
    logic [11:0] smp_a, smp_b, smp_c;
    logic [89:0] coef_bus;
    logic [15:0] chain_in;
    logic [15:0] chain_out;
    logic        chain_valid;

    always #10 clk = ~clk;

    conv_cascade_mac dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .smp_a       (smp_a),
        .smp_b       (smp_b),
        .smp_c       (smp_c),
        .coef_bus    (coef_bus),
        .chain_in    (chain_in),
        .chain_out   (chain_out),
        .chain_valid (chain_valid)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    int    t = -1;
    string phase_tag = "";

    int a_h [64];
    int b_h [64];
    int c_h [64];
    int cas_h [64];
    int rst_h [64];
    int mode_h [64];
    int k_h [64][9];

    function automatic int ah(int d); return a_h[(t - d) & 63]; endfunction
    function automatic int bh(int d); return b_h[(t - d) & 63]; endfunction
    function automatic int ch(int d); return c_h[(t - d) & 63]; endfunction
    function automatic int wv(int i); return k_h[(t - 2) & 63][i]; endfunction

    function automatic int model_products(int m);
        int p;
        p = wv(2)*ah(4) + wv(1)*ah(5) + wv(0)*ah(6);
        if (m == 1) begin
            p += wv(5)*bh(7) + wv(4)*bh(8) + wv(3)*bh(9)
               + wv(8)*bh(10) + wv(7)*bh(11) + wv(6)*bh(12);
        end else if (m == 2) begin
            p += wv(5)*bh(4) + wv(4)*bh(5) + wv(3)*bh(6)
               + wv(8)*ch(4) + wv(7)*ch(5) + wv(6)*ch(6);
        end else begin
            // 4x2: weight slot 7 deliberately absent
            p += wv(8)*ah(7) + wv(5)*bh(4) + wv(4)*bh(5) + wv(3)*bh(6) + wv(6)*bh(7);
        end
        return p;
    endfunction

    task automatic check_now();
        int    m;
        int    lat;
        bit    ev;
        int    expo;
        logic [15:0] e16;
        string vt;
        string dt;
        m  = mode_h[t & 63];
        ev = 1'b1;
        lat = (m == 1) ? 12 : (m == 2) ? 6 : 7;
        if (m == 0 || t < lat) ev = 1'b0;
        else begin
            for (int d = 0; d <= lat; d++) begin
                if (rst_h[(t - d) & 63] != 0 || mode_h[(t - d) & 63] != m) ev = 1'b0;
            end
        end
        expo = 0;
        if (ev) expo = ((model_products(m) + 32) >>> 6) + cas_h[(t - 3) & 63];
        e16 = expo[15:0];
        vt = (phase_tag != "") ? phase_tag : "R8";
        dt = (phase_tag != "") ? phase_tag :
             (!ev ? "R9" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5");
        n_checks++;
        if (chain_valid !== ev) begin
            n_errors++;
            $display("FAIL %s: chain_valid=%0b expected %0b at edge %0d", vt, chain_valid, ev, t);
        end
        n_checks++;
        if (chain_out !== e16) begin
            n_errors++;
            $display("FAIL %s: chain_out=%h expected %h at edge %0d", dt, chain_out, e16, t);
        end
    endtask

    task automatic tick();
        int idx;
        @(posedge clk);
        t++;
        idx = t & 63;
        a_h[idx]    = $signed(smp_a);
        b_h[idx]    = $signed(smp_b);
        c_h[idx]    = $signed(smp_c);
        cas_h[idx]  = $signed(chain_in);
        rst_h[idx]  = rst ? 1 : 0;
        mode_h[idx] = int'(mode_sel);
        for (int i = 0; i < 9; i++) k_h[idx][i] = $signed(coef_bus[i*10 +: 10]);
        @(negedge clk);
        check_now();
    endtask

    task automatic rand_inputs(bit same_ab);
        smp_a    = 12'($urandom);
        smp_b    = same_ab ? smp_a : 12'($urandom);
        smp_c    = 12'($urandom);
        chain_in = 16'($urandom);
    endtask

    task automatic run_rand(int n, bit same_ab);
        for (int i = 0; i < n; i++) begin
            rand_inputs(same_ab);
            tick();
        end
    endtask

    task automatic set_coefs_all(int v);
        for (int i = 0; i < 9; i++) coef_bus[i*10 +: 10] = 10'(v);
    endtask

    task automatic set_coefs_rand();
        for (int i = 0; i < 9; i++) coef_bus[i*10 +: 10] = 10'($urandom);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        $display("FAIL watchdog: run still active (actual hung, expected finished)");
        summary();
        $finish;
    end

    initial begin
        int modes [7];
        int lens  [7];
        modes = '{1, 3, 2, 0, 2, 3, 1};
        lens  = '{20, 3, 15, 5, 10, 9, 25};
        for (int i = 0; i < 64; i++) begin
            rst_h[i] = 1; mode_h[i] = 0;
        end
        rst = 1'b1; mode_sel = 2'b00;
        smp_a = '0; smp_b = '0; smp_c = '0; coef_bus = '0; chain_in = '0;

        // R1: reset state
        phase_tag = "R1";
        repeat (4) tick();
        rst = 1'b0;

        // R2: idle mode keeps output flushed
        phase_tag = "R2";
        set_coefs_rand();
        run_rand(20, 1'b0);

        // R3: FIR impulse response, then random FIR stream
        phase_tag = "";
        for (int i = 0; i < 9; i++) coef_bus[i*10 +: 10] = 10'(40 * (i + 1));
        mode_sel = 2'b01;
        smp_a = '0; smp_b = '0; chain_in = '0;
        repeat (16) tick();
        smp_a = 12'd100; smp_b = 12'd100;
        tick();
        smp_a = '0; smp_b = '0;
        repeat (20) tick();
        set_coefs_rand();
        run_rand(80, 1'b1);

        // R6: chain input path alone, two modes
        phase_tag = "R6";
        set_coefs_all(0);
        run_rand(30, 1'b1);
        mode_sel = 2'b10;
        run_rand(30, 1'b0);

        // R7: rounding of small sums
        phase_tag = "R7";
        set_coefs_all(1);
        for (int i = 0; i < 60; i++) begin
            smp_a = 12'($urandom_range(80) - 40);
            smp_b = 12'($urandom_range(80) - 40);
            smp_c = 12'($urandom_range(80) - 40);
            chain_in = 16'($urandom_range(6) - 3);
            tick();
        end

        // R4: 3x3 random
        phase_tag = "";
        set_coefs_rand();
        run_rand(80, 1'b0);

        // R5: 4x2 with slot 7 changing every cycle
        mode_sel = 2'b11;
        for (int i = 0; i < 80; i++) begin
            rand_inputs(1'b0);
            coef_bus[7*10 +: 10] = 10'($urandom);
            tick();
        end

        // R7: extreme operands must not wrap before rounding
        phase_tag = "R7";
        mode_sel = 2'b10;
        set_coefs_all(-512);
        smp_a = 12'h800; smp_b = 12'h800; smp_c = 12'h800; chain_in = 16'h7fff;
        repeat (20) tick();
        smp_a = 12'h7ff; smp_b = 12'h7ff; smp_c = 12'h7ff; chain_in = 16'h8000;
        repeat (20) tick();

        // R9: mode switches, some shorter than the new latency
        phase_tag = "R9";
        set_coefs_rand();
        for (int s = 0; s < 7; s++) begin
            mode_sel = 2'(modes[s]);
            run_rand(lens[s], modes[s] == 1);
        end

        // R1: reset in mid-stream, then recovery
        phase_tag = "R1";
        rst = 1'b1;
        run_rand(2, 1'b1);
        rst = 1'b0;
        phase_tag = "";
        run_rand(20, 1'b1);

        summary();
        $finish;
    end

endmodule